// File: doc/BRIEF.md
# Oversampled Setup/Hold Violation Detector

This block receives one oversampled snapshot per clock cycle: a vector of data channels and one bit carrying the sampled clock line. Each cycle is one fine sample period. The block finds the active edges of the sampled clock. For each edge it checks whether any data channel changed inside a window set by two signed offsets, measured in samples from the edge sample. A hit gives a single-cycle flag, a mask of the offending channels and the sample number of the edge. The flag can feed a trigger sequencer or a capture qualifier.

The two offsets are independent. The window may straddle the edge, lie entirely before it or lie entirely after it. The setup offset gives the earliest sample of the window and the hold offset gives the latest. Each edge is judged at a fixed delay. By then every sample in the largest window has been seen, so edges that come close together are each judged on their own.

Top module: `shd_sh_detect`

## Requirements
- R1: While rst_n is low, and after release until the first result, viol_o and viol_mask_o are 0 and viol_idx_o is 0.
- R2: With edge_rise = 1, an active edge is a sample where smp_clk is 1 and the previous sample's smp_clk was 0. With edge_rise = 0 the roles of 1 and 0 swap. Edges of the other polarity never produce a flag.
- R3: Channel c transitions at sample s when its bit differs from the same bit at sample s-1. The sample before the first one after reset counts as all zeros, with smp_clk 0.
- R4: Offsets are 6-bit two's complement: setup_off in -16..+14 and hold_off in -14..+16. A transition at sample e+k, where e is the edge sample, flags its channel exactly when setup_off <= k <= hold_off, bounds included.
- R5: Windows lying wholly after the edge (setup_off > 0) or wholly before it (hold_off < 0) are evaluated with the same rule.
- R6: When setup_off > hold_off the window is empty and viol_o stays 0.
- R7: A sample presented at clock edge n that is an active edge with a violation raises viol_o for exactly the one cycle that follows clock edge n+17. The offsets and edge_rise must be steady from that sample until then.
- R8: viol_mask_o bit c is 1 when channel c transitioned in the window. viol_o is the OR of the mask. The mask is 0 whenever viol_o is 0.
- R9: viol_idx_o holds the index of the violating edge sample: the first sample after reset is 0, and the count wraps modulo 2^16. It holds its value until the next violation.
- R10: Every active edge is evaluated independently, even when its window overlaps the window of an earlier edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fine sample clock, one sample per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_data | input | CH | Data channel samples |
| smp_clk | input | 1 | Sampled level of the observed clock line |
| edge_rise | input | 1 | 1: rising edges are active; 0: falling |
| setup_off | input | 6 | Signed earliest window offset in samples |
| hold_off | input | 6 | Signed latest window offset in samples |
| viol_o | output | 1 | One-cycle violation flag |
| viol_mask_o | output | CH | Channels that transitioned in the window |
| viol_idx_o | output | IDX_W | Sample index of the violating edge |

## Verification
The hardest case to reach from the ports is two active edges whose windows overlap, at the same time as a channel toggling exactly on a window bound. One segment of the stimulus drives a sampled clock with a period of four samples under the widest window. Other segments place single toggles one sample inside and one sample outside each bound of every qualifying edge. Random segments with random offsets, polarities and clock periods cover empty windows and windows lying wholly before or wholly after the edge. A sample-by-sample reference model in the bench predicts every output cycle.

// File: rtl/shd_pkg.sv
package shd_pkg;
    parameter int unsigned SHD_OFF_W = 6;
    typedef logic signed [SHD_OFF_W-1:0] off_t;
    typedef enum logic {POL_FALL = 1'b0, POL_RISE = 1'b1} pol_e;
endpackage

// File: rtl/shd_xition_det.sv
module shd_xition_det #(
    parameter int CH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CH-1:0] data_i,
    input  logic          sclk_i,
    input  logic          rise_i,
    output logic [CH-1:0] xition_o,
    output logic          edge_o
);
    import shd_pkg::*;

    typedef struct packed {
        logic [CH-1:0] prev_data;
        logic          prev_clk;
    } st_t;

    st_t st_d, st_q;
    pol_e pol;

    always_comb begin
        st_d           = st_q;
        st_d.prev_data = data_i;
        st_d.prev_clk  = sclk_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // per-channel change against the previous sample
    assign pol      = pol_e'(rise_i);
    assign xition_o = data_i ^ st_q.prev_data;
    assign edge_o   = (sclk_i == pol) && (st_q.prev_clk != pol);
endmodule

// File: rtl/shd_hist_line.sv
module shd_hist_line #(
    parameter int CH       = 8,
    parameter int DEPTH    = 33,
    parameter int EDGE_AGE = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CH-1:0]             xition_i,
    input  logic                      edge_i,
    output logic [DEPTH-1:0][CH-1:0]  xh_o,
    output logic                      edge_due_o
);
    typedef struct packed {
        logic [DEPTH-1:0][CH-1:0] xh;
        logic [EDGE_AGE:0]        eh;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.xh[0] = xition_i;
        st_d.eh[0] = edge_i;
        for (int i = 1; i < DEPTH; i++) begin
            st_d.xh[i] = st_q.xh[i-1];
        end
        for (int i = 1; i <= EDGE_AGE; i++) begin
            st_d.eh[i] = st_q.eh[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign xh_o       = st_q.xh;
    assign edge_due_o = st_q.eh[EDGE_AGE];
endmodule

// File: rtl/shd_window_eval.sv
module shd_window_eval #(
    parameter int CH   = 8,
    parameter int PRE  = 16,
    parameter int POST = 16
) (
    input  logic [PRE+POST:0][CH-1:0] xh_i,
    input  shd_pkg::off_t             setup_i,
    input  shd_pkg::off_t             hold_i,
    output logic [CH-1:0]             mask_o
);
    localparam int DEPTH = PRE + POST + 1;

    logic [DEPTH-1:0] in_win;

    // history age j holds the transition at offset POST-j from the edge
    for (genvar j = 0; j < DEPTH; j++) begin : g_win
        localparam int K = POST - j;
        assign in_win[j] = (int'(setup_i) <= K) && (K <= int'(hold_i));
    end

    always_comb begin
        mask_o = '0;
        for (int j = 0; j < DEPTH; j++) begin
            mask_o = mask_o | (xh_i[j] & {CH{in_win[j]}});
        end
    end
endmodule

// File: rtl/shd_sh_detect.sv
module shd_sh_detect #(
    parameter int CH    = 8,
    parameter int PRE   = 16,
    parameter int POST  = 16,
    parameter int IDX_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CH-1:0]        smp_data,
    input  logic                 smp_clk,
    input  logic                 edge_rise,
    input  logic signed [5:0]    setup_off,
    input  logic signed [5:0]    hold_off,
    output logic                 viol_o,
    output logic [CH-1:0]        viol_mask_o,
    output logic [IDX_W-1:0]     viol_idx_o
);
    import shd_pkg::*;

    localparam int DEPTH = PRE + POST + 1;
    localparam int LAT   = POST + 1;

    typedef struct packed {
        logic             viol;
        logic [CH-1:0]    mask;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    logic [CH-1:0]            xition;
    logic                     edge_now;
    logic [DEPTH-1:0][CH-1:0] xh;
    logic                     edge_due;
    logic [CH-1:0]            win_mask;
    logic                     hit;

    shd_xition_det #(.CH(CH)) det_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_i   (smp_data),
        .sclk_i   (smp_clk),
        .rise_i   (edge_rise),
        .xition_o (xition),
        .edge_o   (edge_now)
    );

    shd_hist_line #(.CH(CH), .DEPTH(DEPTH), .EDGE_AGE(POST)) hist_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .xition_i   (xition),
        .edge_i     (edge_now),
        .xh_o       (xh),
        .edge_due_o (edge_due)
    );

    shd_window_eval #(.CH(CH), .PRE(PRE), .POST(POST)) win_i (
        .xh_i    (xh),
        .setup_i (off_t'(setup_off)),
        .hold_i  (off_t'(hold_off)),
        .mask_o  (win_mask)
    );

    assign hit = edge_due && (|win_mask);

    always_comb begin
        st_d      = st_q;
        st_d.cnt  = st_q.cnt + 1'b1;
        st_d.viol = hit;
        st_d.mask = hit ? win_mask : '0;
        if (hit) begin
            // edge under evaluation was counted LAT samples ago
            st_d.idx = st_q.cnt - IDX_W'(LAT);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign viol_o      = st_q.viol;
    assign viol_mask_o = st_q.mask;
    assign viol_idx_o  = st_q.idx;
endmodule

// File: rtl/shd_sh_detect_chk.sv
module shd_sh_detect_chk #(
    parameter int CH    = 8,
    parameter int POST  = 16,
    parameter int IDX_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic signed [5:0] setup_off,
    input logic signed [5:0] hold_off,
    input logic              viol_o,
    input logic [CH-1:0]     viol_mask_o,
    input logic [IDX_W-1:0]  viol_idx_o
);
    logic [IDX_W-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= '0;
        else        seen_q <= seen_q + 1'b1;
    end

    // R8: a flag always names at least one channel
    a_r8_flag_has_mask: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> (viol_mask_o != '0));

    // R8: the mask is quiet without a flag
    a_r8_quiet_mask: assert property (@(posedge clk) disable iff (!rst_n)
        !viol_o |-> (viol_mask_o == '0));

    // R7: the flag lasts one cycle (active edges are at least two samples apart)
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |=> !viol_o);

    // R6: no flag is judged under an empty window
    a_r6_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> $past(int'(setup_off) <= int'(hold_off)));

    // R9: the reported index lies POST+2 samples behind the checker's own count
    a_r9_index: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> (viol_idx_o == seen_q - IDX_W'(POST + 2)));

    // R9: the index holds between violations
    a_r9_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !viol_o |-> $stable(viol_idx_o));
endmodule

bind shd_sh_detect shd_sh_detect_chk #(.CH(CH), .POST(POST), .IDX_W(IDX_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .setup_off   (setup_off),
    .hold_off    (hold_off),
    .viol_o      (viol_o),
    .viol_mask_o (viol_mask_o),
    .viol_idx_o  (viol_idx_o)
);

// File: tb/shd_sh_detect_tb_top.sv
module shd_sh_detect_tb_top;
    localparam int CH    = 8;
    localparam int PRE   = 16;
    localparam int POST  = 16;
    localparam int IDX_W = 16;
    localparam int LAT   = POST + 1;
    localparam int MAXS  = 8192;
    localparam int BUF   = 512;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [CH-1:0]       smp_data = '0;
    logic                smp_clk = 1'b0;
    logic                edge_rise = 1'b1;
    logic signed [5:0]   setup_off = '0;
    logic signed [5:0]   hold_off = '0;
    logic                viol_o;
    logic [CH-1:0]       viol_mask_o;
    logic [IDX_W-1:0]    viol_idx_o;

    always #10 clk = ~clk;

    shd_sh_detect #(.CH(CH), .PRE(PRE), .POST(POST), .IDX_W(IDX_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_data    (smp_data),
        .smp_clk     (smp_clk),
        .edge_rise   (edge_rise),
        .setup_off   (setup_off),
        .hold_off    (hold_off),
        .viol_o      (viol_o),
        .viol_mask_o (viol_mask_o),
        .viol_idx_o  (viol_idx_o)
    );

    logic [CH-1:0]    h_d  [MAXS];
    logic             h_c  [MAXS];
    logic             h_p  [MAXS];
    int               h_su [MAXS];
    int               h_ho [MAXS];
    int               g      = 0;
    int               n_chk  = 0;
    int               n_fail = 0;
    int               n_viol = 0;
    logic [IDX_W-1:0] exp_idx = '0;
    bit               ended  = 1'b0;

    function automatic logic [CH-1:0] tr(int s);
        if (s < 0) return '0;
        if (s == 0) return h_d[0];
        return h_d[s] ^ h_d[s-1];
    endfunction

    function automatic logic ed(int s);
        logic pc;
        if (s < 0) return 1'b0;
        pc = (s == 0) ? 1'b0 : h_c[s-1];
        return (h_c[s] == h_p[s]) && (pc != h_p[s]);
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // expected outputs just after clock edge g
    task automatic check(input string tag);
        int e;
        logic [CH-1:0] m;
        logic v;
        e = g - LAT;
        m = '0;
        if (ed(e)) begin
            for (int k = h_su[g]; k <= h_ho[g]; k++) m = m | tr(e + k);
        end
        v = (m != '0);
        if (!v) m = '0;
        if (v) begin
            exp_idx = IDX_W'(e);
            n_viol++;
        end
        n_chk++;
        if (viol_o !== v || viol_mask_o !== m || viol_idx_o !== exp_idx) begin
            n_fail++;
            $display("FAIL %s sample %0d: got viol=%0b mask=%h idx=%0d, expected viol=%0b mask=%h idx=%0d",
                     tag, g, viol_o, viol_mask_o, viol_idx_o, v, m, exp_idx);
        end
    endtask

    task automatic step(input logic [CH-1:0] d, input logic c, input string tag);
        if (g >= MAXS) return;
        smp_data = d;
        smp_clk  = c;
        h_d[g]   = d;
        h_c[g]   = c;
        h_p[g]   = edge_rise;
        h_su[g]  = int'(setup_off);
        h_ho[g]  = int'(hold_off);
        @(posedge clk);
        @(negedge clk);
        check(tag);
        g++;
    endtask

    // kind 0: random toggles with probability p/256; kind 1: toggles at the window bounds
    task automatic run_seg(input string tag, input int su, input int ho, input bit pol,
                           input int hp, input int kind, input int len, input int p);
        logic [CH-1:0] tog [BUF];
        logic          ck  [BUF];
        logic [CH-1:0] cur;
        int            ph;
        setup_off = 6'(su);
        hold_off  = 6'(ho);
        edge_rise = pol;
        ph = $urandom_range(2 * hp - 1, 0);
        for (int i = 0; i < len; i++) begin
            ck[i]  = 1'(((i + ph) / hp) % 2);
            tog[i] = '0;
        end
        for (int i = 0; i < len; i++) begin
            if (kind == 0) begin
                for (int c = 0; c < CH; c++) begin
                    if ($urandom_range(255, 0) < p) tog[i][c] = 1'b1;
                end
            end else if (i > 0 && ck[i] == pol && ck[i-1] != pol) begin
                if (i + su - 1 >= 0 && i + su - 1 < len) tog[i + su - 1][0] = 1'b1;
                if (i + su >= 0 && i + su < len)         tog[i + su][1]     = 1'b1;
                if (i + ho >= 0 && i + ho < len)         tog[i + ho][2]     = 1'b1;
                if (i + ho + 1 >= 0 && i + ho + 1 < len) tog[i + ho + 1][3] = 1'b1;
                if (su <= ho && i + (su + ho) / 2 >= 0 && i + (su + ho) / 2 < len)
                    tog[i + (su + ho) / 2][4] = 1'b1;
            end
        end
        cur = smp_data;
        for (int i = 0; i < len; i++) begin
            cur = cur ^ tog[i];
            step(cur, ck[i], tag);
        end
        for (int i = 0; i < 20; i++) step(cur, ck[len-1], tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = 32'h5eed_0c1d;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1: reset state
        n_chk++;
        if (viol_o !== 1'b0 || viol_mask_o !== '0 || viol_idx_o !== '0) begin
            n_fail++;
            $display("FAIL R1 reset: got viol=%0b mask=%h idx=%0d, expected 0 0 0",
                     viol_o, viol_mask_o, viol_idx_o);
        end
        rst_n = 1'b1;
        // R4: straddling window, toggles on and just outside each bound
        run_seg("R4 straddle bounds", -3, 4, 1'b1, 20, 1, 200, 0);
        run_seg("R4 widest bounds", -16, 16, 1'b1, 24, 1, 240, 0);
        run_seg("R3 R4 narrow single sample", 0, 0, 1'b1, 9, 1, 150, 0);
        // R5: windows wholly after and wholly before the edge
        run_seg("R5 after edge", 3, 10, 1'b1, 20, 1, 200, 0);
        run_seg("R5 before edge", -16, -9, 1'b1, 20, 1, 200, 0);
        run_seg("R5 late limits", 14, 16, 1'b1, 20, 1, 160, 0);
        // R6: empty windows under heavy activity
        run_seg("R6 empty window", 5, 2, 1'b1, 6, 0, 200, 90);
        run_seg("R6 inverted extremes", 14, -14, 1'b0, 5, 0, 200, 90);
        // R2: falling polarity
        run_seg("R2 falling bounds", -4, 4, 1'b0, 12, 1, 200, 0);
        run_seg("R2 falling random", -6, 2, 1'b0, 7, 0, 200, 20);
        // R10: overlapping windows from close edges
        run_seg("R10 close edges", -16, 16, 1'b1, 2, 0, 240, 6);
        run_seg("R10 close edges falling", -8, 9, 1'b0, 3, 0, 200, 10);
        // R7 R8 R9: constrained random configurations
        for (int r = 0; r < 14; r++) begin
            run_seg("R8 R9 random", $urandom_range(30, 0) - 16, $urandom_range(30, 0) - 14,
                    1'($urandom_range(1, 0)), $urandom_range(25, 2), 0, 300,
                    $urandom_range(40, 2));
        end
        // R7: the random and directed segments must have produced flags
        n_chk++;
        if (n_viol < 20) begin
            n_fail++;
            $display("FAIL R7 stimulus: got %0d expected flags, expected at least 20", n_viol);
        end
        finish_run();
    end
endmodule